// File: doc/BRIEF.md
# Three-Wire Control Register with Band Outputs

This block takes a 24-bit control word from a host over three wires: an enable, a shift clock and a serial data line. All three are brought into the system clock domain through a synchroniser chain. While the enable is high, each rising edge of the shift clock moves one data bit into a holding register, least significant bit first. The word becomes active only when the enable falls, and only if exactly 24 shift clocks were seen. A word whose two test bits are not both zero is refused and flagged with a one-cycle error pulse.

The active word drives the divisor value, the reference-step code and the FM/AM select for the neighbouring divider and reference blocks. In AM mode the divider uses only the upper ten divisor bits. The word also drives three band outputs. A free-running timebase divider makes a slow square wave that can replace the first band output when the word asks for it. If all three band bits are zero, the band outputs show the reference code.

Top module: `twc_ctrl_reg`

## Requirements
- R1: During reset and after it, until the first accepted word, div_o, ref_o, fm_sel_o, band_o and err_o are all zero.
- R2: Bit i of the word is the i-th data bit shifted in. Bits 13..0 are the divisor, bits 15..14 are the test bits, bits 18..16 are the band bits, bit 19 is the timebase enable, bits 22..20 are the reference code (ref_o) and bit 23 is the select (1 = FM, 0 = AM, on fm_sel_o).
- R3: A word is applied on the third rising system clock edge after the enable is seen low, and only if exactly 24 shift clocks occurred since the previous enable fall. With 23 or 25 clocks, no output changes and err_o stays low.
- R4: A 24-clock word with nonzero test bits is not applied. err_o is high for exactly one cycle, in the cycle where the word would have been applied.
- R5: Rising shift-clock edges while the enable is low are ignored. They neither shift data nor count toward the 24.
- R6: With select = 1, div_o equals divisor bits 13..0. With select = 0, div_o equals divisor bits 13..4, zero-extended.
- R7: With nonzero band bits, band_o[1] = bit 17 and band_o[2] = bit 18. band_o[0] = bit 16 when the timebase enable is 0.
- R8: With band bits all zero, band_o[2:0] equals the reference code bits 22..20. The timebase override of band_o[0] still applies.
- R9: With the timebase enable set, band_o[0] carries a square wave that starts low at reset release and toggles every TB_HALF system clocks. band_o[2:1] are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_i | input | 1 | Serial enable, active high, asynchronous |
| cl_i | input | 1 | Serial shift clock, asynchronous |
| data_i | input | 1 | Serial data, asynchronous |
| div_o | output | 14 | Effective divisor for the programmable divider |
| ref_o | output | 3 | Reference-step code |
| fm_sel_o | output | 1 | Divider input select, 1 = FM |
| band_o | output | 3 | Band outputs, bit 0 may carry the timebase |
| err_o | output | 1 | One-cycle pulse on a refused word |

## Verification
A wrong bit count or a misplaced field shows up on the divisor, reference or band pins on the third cycle after the enable falls. A count that does not reset, or that counts edges while the enable is low, shows up on the next word: the word is refused and the outputs keep their old values. A fault in the timebase divider shows up on band_o[0] within one half-period. The reference model predicts every output on every cycle, so any of these faults is caught in the first cycle it appears.

// File: rtl/twc_pkg.sv
package twc_pkg;

    // Field layout of the serial word, low bit first on the wire.
    localparam int unsigned DIV_W    = 14;
    localparam int unsigned TEST_W   = 2;
    localparam int unsigned BAND_W   = 3;
    localparam int unsigned REF_W    = 3;
    localparam int unsigned AM_DROP  = 4;

    localparam int unsigned DIV_LO   = 0;
    localparam int unsigned TEST_LO  = DIV_LO + DIV_W;
    localparam int unsigned BAND_LO  = TEST_LO + TEST_W;
    localparam int unsigned TB_POS   = BAND_LO + BAND_W;
    localparam int unsigned REF_LO   = TB_POS + 1;
    localparam int unsigned SEL_POS  = REF_LO + REF_W;
    localparam int unsigned WORD_W   = SEL_POS + 1;

    // Settings held once a word is accepted (test bits are never stored).
    typedef struct packed {
        logic              fm_sel;
        logic [REF_W-1:0]  refc;
        logic              tb_en;
        logic [BAND_W-1:0] band;
        logic [DIV_W-1:0]  div;
    } applied_t;

    function automatic logic [DIV_W-1:0] eff_divisor(input applied_t w);
        logic [DIV_W-1:0] r;
        if (w.fm_sel) r = w.div;
        else          r = w.div >> AM_DROP;
        return r;
    endfunction

endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.chain = (st_q.chain << 1) | STAGES'(din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.chain[STAGES-1];
endmodule

// File: rtl/twc_shift_rx.sv
module twc_shift_rx
    import twc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_lvl,
    input  logic     cl_lvl,
    input  logic     dat_lvl,
    output applied_t word_o,
    output logic     err_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              ce_prev;
        logic              cl_prev;
        applied_t          word;
        logic              err;
    } rx_t;

    rx_t  st_d, st_q;
    logic ce_fall;
    logic cl_rise;

    assign ce_fall = st_q.ce_prev & ~ce_lvl;
    assign cl_rise = cl_lvl & ~st_q.cl_prev;

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_lvl;
        st_d.cl_prev = cl_lvl;
        st_d.err     = 1'b0;
        if (ce_fall) begin
            if (st_q.cnt == CNT_FULL) begin
                if (st_q.sr[TEST_LO +: TEST_W] == '0) begin
                    st_d.word.div    = st_q.sr[DIV_LO +: DIV_W];
                    st_d.word.band   = st_q.sr[BAND_LO +: BAND_W];
                    st_d.word.tb_en  = st_q.sr[TB_POS];
                    st_d.word.refc   = st_q.sr[REF_LO +: REF_W];
                    st_d.word.fm_sel = st_q.sr[SEL_POS];
                end else begin
                    st_d.err = 1'b1;
                end
            end
            st_d.cnt = '0;
        end else if (ce_lvl && cl_rise) begin
            st_d.sr = {dat_lvl, st_q.sr[WORD_W-1:1]};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;
    assign err_o  = st_q.err;
endmodule

// File: rtl/twc_timebase.sv
module twc_timebase #(
    parameter int unsigned HALF = 450000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tb_o
);
    localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tb;
    } tb_t;

    tb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.tb  = ~st_q.tb;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tb_o = st_q.tb;
endmodule

// File: rtl/twc_band_dec.sv
module twc_band_dec
    import twc_pkg::*;
(
    input  applied_t          word,
    input  logic              tb_lvl,
    output logic [BAND_W-1:0] band_o,
    output logic [DIV_W-1:0]  div_o
);
    logic [BAND_W-1:0] src;

    always_comb begin
        // An all-zero band field hands the pins over to the reference code.
        if (word.band == '0) src = word.refc;
        else                 src = word.band;
        band_o = src;
        if (word.tb_en) band_o[0] = tb_lvl;
        div_o = eff_divisor(word);
    end
endmodule

// File: rtl/twc_ctrl_reg.sv
module twc_ctrl_reg
    import twc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TB_HALF     = 450000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_i,
    input  logic               cl_i,
    input  logic               data_i,
    output logic [DIV_W-1:0]   div_o,
    output logic [REF_W-1:0]   ref_o,
    output logic               fm_sel_o,
    output logic [BAND_W-1:0]  band_o,
    output logic               err_o
);
    localparam int unsigned N_PINS = 3;

    logic [N_PINS-1:0] pin_raw;
    logic [N_PINS-1:0] pin_lvl;
    applied_t          word;
    logic              tb_lvl;

    assign pin_raw = {data_i, cl_i, ce_i};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        twc_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[g]),
            .lvl  (pin_lvl[g])
        );
    end

    twc_shift_rx i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_lvl (pin_lvl[0]),
        .cl_lvl (pin_lvl[1]),
        .dat_lvl(pin_lvl[2]),
        .word_o (word),
        .err_o  (err_o)
    );

    twc_timebase #(.HALF(TB_HALF)) i_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .tb_o (tb_lvl)
    );

    twc_band_dec i_dec (
        .word  (word),
        .tb_lvl(tb_lvl),
        .band_o(band_o),
        .div_o (div_o)
    );

    assign ref_o    = word.refc;
    assign fm_sel_o = word.fm_sel;
endmodule

// File: rtl/twc_ctrl_reg_chk.sv
module twc_ctrl_reg_chk #(
    parameter int unsigned LAT = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_i,
    input logic        err_o,
    input logic [13:0] div_o,
    input logic [2:0]  ref_o,
    input logic        fm_sel_o,
    input logic        tb_lvl
);
    AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R4

    AST_ERR_NEEDS_CE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !$past(ce_i, LAT)); // R4

    AST_WORD_HELD_WHILE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_i, LAT) |-> ($stable(div_o) && $stable(ref_o) && $stable(fm_sel_o))); // R3

    AST_AM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !fm_sel_o |-> (div_o[13:10] == 4'd0)); // R6

    AST_TB_NO_FAST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tb_lvl) |=> $stable(tb_lvl)); // R9
endmodule

bind twc_ctrl_reg twc_ctrl_reg_chk #(.LAT(SYNC_STAGES + 1)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_i    (ce_i),
    .err_o   (err_o),
    .div_o   (div_o),
    .ref_o   (ref_o),
    .fm_sel_o(fm_sel_o),
    .tb_lvl  (tb_lvl)
);

// File: tb/test_twc_ctrl_reg.sv
`timescale 1ns/1ps
module test_twc_ctrl_reg;
    localparam int HALF = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, cl = 1'b0, dat = 1'b0;
    logic [13:0] div_o;
    logic [2:0]  ref_o, band_o;
    logic        fm_sel_o, err_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0, mon_en = 0;

    logic [23:0] exp_word = '0;
    logic        exp_err  = 1'b0;
    int          m_cnt = 0;
    logic        m_tb  = 1'b0;

    always #5 clk = ~clk;

    twc_ctrl_reg #(.TB_HALF(HALF)) i_twc_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .data_i(dat),
        .div_o(div_o), .ref_o(ref_o), .fm_sel_o(fm_sel_o),
        .band_o(band_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit fm, input bit [2:0] rc, input bit tb,
                                       input bit [2:0] bd, input bit [1:0] ts, input int dv);
        return {8'd0, fm, rc, tb, bd, ts, dv[13:0]};
    endfunction

    // Behavioural timebase: half period HALF clocks, low from reset release.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tb = 1'b0;
        end else if (m_cnt == HALF - 1) begin
            m_cnt = 0; m_tb = ~m_tb;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (mon_en) begin
            logic [13:0] d;
            logic [2:0]  bd, rc, eb;
            logic        fm, tbe;
            d   = exp_word[13:0];
            bd  = exp_word[18:16];
            tbe = exp_word[19];
            rc  = exp_word[22:20];
            fm  = exp_word[23];
            eb  = (bd == 3'd0) ? rc : bd;
            if (tbe) eb[0] = m_tb;
            chk("R2 ref_o", ref_o, rc);
            chk("R2 fm_sel_o", fm_sel_o, fm);
            chk("R6 div_o", div_o, fm ? int'(d) : int'(d >> 4));
            chk("R7 band_o", band_o, eb);
            chk("R4 err_o", err_o, exp_err);
        end
    end

    task automatic send(input logic [31:0] bits, input int n);
        @(negedge clk) ce = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            dat = bits[i];
            repeat (3) @(negedge clk);
            cl = 1'b1;
            repeat (3) @(negedge clk);
            cl = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        ce = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        if (n == 24) begin
            if (bits[15:14] == 2'b00) exp_word = bits[23:0];
            else begin
                exp_err = 1'b1;
                @(posedge clk); #1;
                exp_err = 1'b0;
            end
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            report();
        end
    end

    initial begin
        int toggles;
        int errs;
        logic prev;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 div_o", div_o, 0);
        chk("R1 band_o", band_o, 0);
        chk("R1 ref_o/fm", {ref_o, fm_sel_o}, 0);
        chk("R1 err_o", err_o, 0);
        rst_n = 1'b1;
        mon_en = 1;
        repeat (5) @(negedge clk);
        chk("R1 after release", {div_o, band_o}, 0);

        // R2/R7: FM word, divisor 1007, band 101, ref 011
        send(mk(1, 3'b011, 0, 3'b101, 2'b00, 1007), 24);
        @(negedge clk);
        chk("R2 divisor FM", div_o, 1007);
        chk("R2 ref code", ref_o, 3);
        chk("R7 band direct", band_o, 3'b101);

        // R6: AM uses upper ten bits, 2320 >> 4 = 145
        send(mk(0, 3'b100, 0, 3'b010, 2'b00, 2320), 24);
        @(negedge clk);
        chk("R6 AM divisor", div_o, 145);
        chk("R6 fm_sel low", fm_sel_o, 0);

        // R8: band field zero shows reference code
        send(mk(1, 3'b110, 0, 3'b000, 2'b00, 500), 24);
        @(negedge clk);
        chk("R8 band from ref", band_o, 3'b110);

        // R9: timebase on band_o[0]
        send(mk(1, 3'b001, 1, 3'b011, 2'b00, 77), 24);
        @(negedge clk);
        prev = band_o[0];
        toggles = 0;
        for (int k = 0; k < 10 * HALF; k++) begin
            @(negedge clk);
            if (band_o[0] !== prev) toggles++;
            prev = band_o[0];
            if (band_o[2:1] !== 2'b01) toggles = toggles + 100;
        end
        chk("R9 toggles in window", toggles, 10);

        // R3: 23 and 25 clocks leave the outputs untouched
        send(mk(0, 3'b111, 0, 3'b110, 2'b00, 999), 23);
        @(negedge clk);
        chk("R3 short word ignored", ref_o, 1);
        send(mk(0, 3'b111, 0, 3'b110, 2'b00, 999), 25);
        @(negedge clk);
        chk("R3 long word ignored", div_o, 77);

        // R4: test bits nonzero -> refused, one error pulse
        errs = 0;
        fork
            send(mk(0, 3'b010, 0, 3'b111, 2'b10, 4000), 24);
            begin
                for (int k = 0; k < 260; k++) begin
                    @(negedge clk);
                    if (err_o) errs++;
                end
            end
        join
        chk("R4 error pulse count", errs, 1);
        chk("R4 word not applied", ref_o, 1);

        // R5: shift clocks with enable low are ignored
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) cl = 1'b1;
            repeat (3) @(negedge clk);
            cl = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk("R5 idle clocks no change", div_o, 77);
        send(mk(0, 3'b111, 0, 3'b100, 2'b00, 16383), 24);
        @(negedge clk);
        chk("R5 next word accepted", div_o, 1023);
        chk("R5 band after idle", band_o, 3'b100);

        repeat (5) @(negedge clk);
        done = 1;
        report();
    end
endmodule